// File: doc/BRIEF.md
# Host Command Mailbox, Device Side

This block is the device end of a register-mapped command mailbox. A host fills a command word (a 16-bit opcode and a 21-bit payload length) and a 256-byte payload buffer. It then sets a doorbell bit to pass ownership of the mailbox to the device. While the doorbell is set, the mailbox is busy and host changes to its contents are refused.

The block hands the opcode and input length to an internal executor through a start/done handshake. The executor is a stub with a fixed latency that answers a few test opcodes. On completion the block writes the return code into the status register. On success it also writes the clamped output length into the command register, and then it clears the doorbell. From that point the command, status and payload contents stay frozen until the host writes them again.

A separate device status register carries a mailbox-ready flag, which rises a configurable number of cycles after reset. The same register carries two device condition flags, one for a fatal error and one for halted firmware.

Top module: `cmd_mailbox`

## Requirements
- R1: The ready flag (device status word 5, bit 2) reads 0 after reset and becomes 1 once READY_DELAY cycles have elapsed. A doorbell write made before then is ignored.
- R2: The capability word (word 0, bits 4:0) reads the buffer size exponent BUF_EXP (8, meaning 256 bytes). All other bits of that word read 0.
- R3: Writing 1 to control word 1 bit 0 sets the doorbell, which reads back as 1 while the command runs. The doorbell returns to 0 only when the command completes, within EXEC_LAT+4 cycles.
- R4: The command register is split across two words. Word 2 holds the opcode in bits 15:0 and length bits 15:0 in bits 31:16. Word 3 holds length bits 20:16 in bits 4:0. Both words read back as written while the mailbox is idle, and writes honour the byte enables.
- R5: The payload buffer holds 64 words at word addresses 64 to 127. Each word reads back what was written, with only the enabled bytes updated.
- R6: While the doorbell is set, writes to the command words and the payload are dropped. A further doorbell write during that time starts nothing.
- R7: On completion, status word 4 bits 15:0 hold the return code, and 0 means success. On success the length field is replaced by the output length. On failure the length field is left unchanged.
- R8: An output length larger than 256 is written back as 256.
- R9: After the doorbell clears, the command, status and payload contents stay unchanged until the host writes them.
- R10: The device status word mirrors the fatal input in bit 0 and the firmware-halted input in bit 1.
- R11: The stub executor answers four cases:
  - opcode 0x0001 echoes the payload unchanged and returns the input length;
  - opcode 0x0002 inverts payload word 0 and returns length 4;
  - opcode 0x0003 reports length 0x1FFFFF;
  - any other opcode returns code 0x0002 and leaves the payload unchanged.
- R12: The executor start is a one-cycle pulse. The doorbell clears on the cycle after the executor's done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the word at addr |
| addr | input | 7 | Word address |
| wdata | input | 32 | Write data |
| wbe | input | 4 | Byte enables for a write |
| rdata | output | 32 | Read data for addr, combinational |
| fatal_in | input | 1 | Device fatal condition |
| fw_halt_in | input | 1 | Firmware halted condition |

## Verification
The hardest situation to reach from the ports is a host write that arrives while a command is still running. The stimulus must land a command-word write, a payload write and a second doorbell write inside the short busy window. The bench issues these writes on the cycles directly after the ring, before it polls for completion. After completion it checks that none of them took effect and that the register contents stay frozen over idle cycles. Random opcodes and lengths up to 511 cover both the clamp path and the path where the length is left unchanged on failure.

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
  parameter int BUF_EXP     = 8,
  parameter int LEN_W       = 21,
  parameter int OP_W        = 16,
  parameter int READY_DELAY = 20,
  parameter int EXEC_LAT    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [6:0]  addr,
  input  logic [31:0] wdata,
  input  logic [3:0]  wbe,
  output logic [31:0] rdata,
  input  logic        fatal_in,
  input  logic        fw_halt_in
);
  localparam int BUF_BYTES = 2 ** BUF_EXP;
  localparam int WORDS     = BUF_BYTES / 4;
  localparam int IDX_W     = $clog2(WORDS);
  localparam int RDY_W     = $clog2(READY_DELAY + 1) + 1;
  localparam int EX_W      = $clog2(EXEC_LAT + 1) + 1;
  localparam int HI_W      = LEN_W - 16;

  localparam logic [6:0] A_CAP = 7'd0, A_CTRL = 7'd1, A_CMDLO = 7'd2,
                         A_CMDHI = 7'd3, A_STAT = 7'd4, A_DEV = 7'd5;

  localparam logic [OP_W-1:0] OP_ECHO = 16'h0001, OP_INV = 16'h0002,
                              OP_BIG = 16'h0003;
  localparam logic [15:0] RC_OK = 16'h0000, RC_UNSUP = 16'h0002;

  function automatic logic [31:0] merge(input logic [31:0] old_v,
                                        input logic [31:0] new_v,
                                        input logic [3:0] be);
    for (int b = 0; b < 4; b++)
      merge[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
  endfunction

  logic              db_q, ready_q, start_q, done_q;
  logic [RDY_W-1:0]  rdy_cnt;
  logic [OP_W-1:0]   cmd_op;
  logic [LEN_W-1:0]  cmd_len;
  logic [15:0]       stat_rc;
  logic [31:0]       pbuf [WORDS];

  logic [EX_W-1:0]   ex_cnt;
  logic [OP_W-1:0]   ex_op;
  logic [LEN_W-1:0]  ex_len;
  logic [15:0]       res_rc;
  logic [LEN_W-1:0]  res_len;

  logic              is_pay, host_ok, ring, done;
  logic [IDX_W-1:0]  pidx;
  logic [15:0]       x_rc;
  logic [LEN_W-1:0]  x_len, clamp_len;
  logic [31:0]       lo_word, hi_word, lo_new, hi_new;

  assign is_pay  = addr[6];
  assign pidx    = addr[IDX_W-1:0];
  assign host_ok = wr_en && !db_q;
  assign ring    = host_ok && addr == A_CTRL && wbe[0] && wdata[0] && ready_q;
  assign done    = ex_cnt == EX_W'(1);

  assign lo_word = {cmd_len[15:0], cmd_op};
  assign hi_word = 32'(cmd_len[LEN_W-1:16]);
  assign lo_new  = merge(lo_word, wdata, wbe);
  assign hi_new  = merge(hi_word, wdata, wbe);

  always_comb begin
    case (ex_op)
      OP_ECHO: begin x_rc = RC_OK;    x_len = ex_len;          end
      OP_INV:  begin x_rc = RC_OK;    x_len = LEN_W'(4);       end
      OP_BIG:  begin x_rc = RC_OK;    x_len = {LEN_W{1'b1}};   end
      default: begin x_rc = RC_UNSUP; x_len = '0;              end
    endcase
  end

  assign clamp_len = (res_len > LEN_W'(BUF_BYTES)) ? LEN_W'(BUF_BYTES) : res_len;

  always_comb begin
    if (is_pay) rdata = pbuf[pidx];
    else begin
      case (addr)
        A_CAP:   rdata = 32'(BUF_EXP);
        A_CTRL:  rdata = {31'b0, db_q};
        A_CMDLO: rdata = lo_word;
        A_CMDHI: rdata = hi_word;
        A_STAT:  rdata = {16'b0, stat_rc};
        A_DEV:   rdata = {29'b0, ready_q, fw_halt_in, fatal_in};
        default: rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_cnt <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      rdy_cnt <= rdy_cnt + 1'b1;
      ready_q <= rdy_cnt >= RDY_W'(READY_DELAY - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_q    <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      ex_cnt  <= '0;
      ex_op   <= '0;
      ex_len  <= '0;
      res_rc  <= '0;
      res_len <= '0;
      stat_rc <= '0;
      cmd_op  <= '0;
      cmd_len <= '0;
    end else begin
      start_q <= ring;
      done_q  <= done;
      if (ring) db_q <= 1'b1;
      if (host_ok && addr == A_CMDLO) begin
        cmd_op        <= lo_new[15:0];
        cmd_len[15:0] <= lo_new[31:16];
      end
      if (host_ok && addr == A_CMDHI)
        cmd_len[LEN_W-1:16] <= hi_new[HI_W-1:0];
      if (start_q) begin
        ex_op  <= cmd_op;
        ex_len <= cmd_len;
        ex_cnt <= EX_W'(EXEC_LAT);
      end else if (ex_cnt != '0) begin
        ex_cnt <= ex_cnt - 1'b1;
      end
      if (done) begin
        res_rc  <= x_rc;
        res_len <= x_len;
      end
      if (done_q) begin
        db_q    <= 1'b0;
        stat_rc <= res_rc;
        if (res_rc == RC_OK) cmd_len <= clamp_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) pbuf[i] <= '0;
    end else begin
      if (host_ok && is_pay)
        pbuf[pidx] <= merge(pbuf[pidx], wdata, wbe);
      if (done && ex_op == OP_INV)
        pbuf[0] <= ~pbuf[0];
    end
  end
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk #(
  parameter int LEN_W = 21,
  parameter int OP_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             db_q,
  input logic             ready_q,
  input logic             start_q,
  input logic             done_q,
  input logic [OP_W-1:0]  cmd_op,
  input logic [LEN_W-1:0] cmd_len,
  input logic [15:0]      stat_rc
);
  a_r1_no_busy_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_q |-> !db_q);

  a_r12_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  a_r12_start_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> db_q);

  a_r12_clear_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !db_q);

  a_r3_clear_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (db_q && !done_q) |=> db_q);

  a_r6_opcode_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    db_q |=> $stable(cmd_op));

  a_r9_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!db_q && !wr_en) |=> ($stable(cmd_op) && $stable(cmd_len) && $stable(stat_rc)));

  a_r8_len_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(db_q) && stat_rc == 16'h0) |-> cmd_len <= LEN_W'(256));
endmodule

bind cmd_mailbox cmd_mailbox_chk #(.LEN_W(LEN_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .db_q(db_q), .ready_q(ready_q),
  .start_q(start_q), .done_q(done_q), .cmd_op(cmd_op), .cmd_len(cmd_len),
  .stat_rc(stat_rc)
);

// File: tb/cmd_mailbox_test.sv
module cmd_mailbox_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [6:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  wbe = 0;
  logic [31:0] rdata;
  logic        fatal_in = 0;
  logic        fw_halt_in = 0;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] model [64];

  always #10 clk = ~clk;

  cmd_mailbox uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d; wbe = be;
    @(negedge clk);
    wr_en = 0; wbe = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] bmerge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    for (int b = 0; b < 4; b++) if (be[b]) o[8*b +: 8] = n[8*b +: 8];
    return o;
  endfunction

  function automatic logic [20:0] exp_len(logic [15:0] op, logic [20:0] inl);
    logic [20:0] l;
    case (op)
      16'h1: l = inl;
      16'h2: l = 21'd4;
      16'h3: l = 21'h1FFFFF;
      default: return inl;
    endcase
    return (l > 21'd256) ? 21'd256 : l;
  endfunction

  function automatic logic [15:0] exp_rc(logic [15:0] op);
    return (op >= 16'h1 && op <= 16'h3) ? 16'h0 : 16'h2;
  endfunction

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    do begin rd(7'd1, v); cyc++; end while (v[0] && cyc < 200);
  endtask

  task automatic run(input logic [15:0] op, input logic [20:0] len, input bit poke);
    logic [31:0] v;
    int cyc;
    wr(7'd2, {len[15:0], op}, 4'hF);
    wr(7'd3, 32'(len[20:16]), 4'hF);
    wr(7'd1, 32'h1, 4'h1);
    rd(7'd1, v); chk("R3 doorbell set", v, 32'h1);
    if (poke) begin
      wr(7'd2, 32'hDEAD_BEEF, 4'hF);
      wr(7'd64 + 7'd5, ~model[5], 4'hF);
      wr(7'd1, 32'h1, 4'h1);
    end
    wait_idle(cyc);
    total++;
    if (cyc >= 12) begin
      bad++;
      $display("FAIL R3 doorbell clear actual=%0d expected<12", cyc);
    end
    if (op == 16'h2) model[0] = ~model[0];
    rd(7'd4, v); chk("R7 return code", v, 32'(exp_rc(op)));
    rd(7'd2, v); chk("R7 R8 length low/opcode", v, {exp_len(op, len)[15:0], op});
    rd(7'd3, v); chk("R7 R8 length high", v, 32'(exp_len(op, len)[20:16]));
    rd(7'd64, v); chk("R11 payload word0", v, model[0]);
    rd(7'd64 + 7'd5, v); chk("R6 R11 payload word5", v, model[5]);
    repeat (5) @(negedge clk);
    rd(7'd1, v); chk("R6 no second command", v, 32'h0);
    rd(7'd4, v); chk("R9 status frozen", v, 32'(exp_rc(op)));
    rd(7'd2, v); chk("R9 command frozen", v, {exp_len(op, len)[15:0], op});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(7'd5, v); chk("R1 not ready after reset", v, 32'h0);
    rd(7'd0, v); chk("R2 capability exponent", v, 32'd8);
    rd(7'd4, v); chk("R7 status reset", v, 32'h0);
    wr(7'd1, 32'h1, 4'h1);
    rd(7'd1, v); chk("R1 doorbell ignored before ready", v, 32'h0);
    repeat (30) @(negedge clk);
    rd(7'd5, v); chk("R1 ready", v, 32'h4);
    fatal_in = 1;
    rd(7'd5, v); chk("R10 fatal flag", v, 32'h5);
    fatal_in = 0; fw_halt_in = 1;
    rd(7'd5, v); chk("R10 firmware halt flag", v, 32'h6);
    fw_halt_in = 0;

    wr(7'd2, 32'h1234_5678, 4'hF);
    wr(7'd2, 32'hAABB_CCDD, 4'b0101);
    rd(7'd2, v); chk("R4 command byte enables", v, 32'h12BB_56DD);
    wr(7'd3, 32'hFFFF_FFFF, 4'hF);
    rd(7'd3, v); chk("R4 length high width", v, 32'h1F);

    wr(7'd64 + 7'd9, 32'h0102_0304, 4'hF);
    wr(7'd64 + 7'd9, 32'hF0F0_F0F0, 4'b1010);
    rd(7'd64 + 7'd9, v); chk("R5 payload byte enables", v, 32'hF002_F004);
    model[9] = 32'hF002_F004;

    for (int i = 0; i < 64; i++) begin
      model[i] = $urandom;
      wr(7'd64 + 7'(i), model[i], 4'hF);
    end
    for (int i = 0; i < 64; i += 9) begin
      rd(7'd64 + 7'(i), v); chk("R5 payload readback", v, model[i]);
    end

    run(16'h1, 21'd40, 1'b1);
    run(16'h2, 21'd8, 1'b0);
    run(16'h3, 21'd0, 1'b0);
    run(16'h7, 21'd99, 1'b1);
    run(16'h1, 21'd256, 1'b0);
    run(16'h1, 21'd257, 1'b0);

    for (int k = 0; k < 30; k++) begin
      logic [15:0] op;
      logic [20:0] len;
      logic [5:0] w;
      logic [3:0] be;
      logic [31:0] d;
      op  = 16'($urandom_range(1, 5));
      len = 21'($urandom_range(0, 511));
      w   = 6'($urandom_range(1, 63));
      be  = 4'($urandom_range(1, 15));
      d   = $urandom;
      wr(7'd64 + 7'(w), d, be);
      model[w] = bmerge(model[w], d, be);
      run(op, len, k[0]);
      rd(7'd64 + 7'(w), v); chk("R11 payload untouched word", v, model[w]);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule